// File: doc/BRIEF.md
# Masked Vector Element Sequencer

This block runs element-wise integer arithmetic across a small file of vector registers. One instruction names a destination vector, two source vectors and a scalar. The sequencer steps through elements 0 up to the active vector length, one element per clock, and sends each through a fixed-latency functional pipeline. The supported operations are add and multiply, each in a vector-vector form and a scalar-vector form, plus an equality compare that writes the mask register instead of a vector.

A per-element mask can gate write-back. A masked-off element still takes its slot in the pipeline, so the elements that follow it keep the same timing. The active length and the mask are copied when an instruction is accepted and stay frozen until it retires. Vector contents are filled and inspected one element at a time through a load port and a read port.

Top module: `vmask_seq`

## Requirements
- R1: With op_i 0 (vector add) the result is Vdst[i] = Vsrca[i] + Vsrcb[i]. With op_i 2 (vector multiply) it is Vdst[i] = Vsrca[i] * Vsrcb[i]. Both keep the low DW bits.
- R2: With op_i 1 (scalar add) the result is Vdst[i] = scalar + Vsrcb[i]. With op_i 3 (scalar multiply) it is Vdst[i] = scalar * Vsrcb[i]. Both keep the low DW bits.
- R3: op_i 4 (compare) sets mask bit i to 1 when Vsrca[i] equals Vsrcb[i] and to 0 otherwise, for every i below the length, whatever use_mask is. Mask bits at or above the length keep their value. No vector is written.
- R4: When use_mask is 1, element i of the destination is written only if bit i of the mask held at acceptance is 1. Masked-off elements leave the destination unchanged and show no wb_we pulse, but they still take their cycle.
- R5: A length write stores min(vl_wdata, MAXVL), visible on vl_o. Only elements 0..length-1 are processed, and destination elements at or above the length keep their value.
- R6: Element i is issued i cycles after the accepting edge. Its write-back appears on the wb_* outputs LAT_ADD (6) cycles later for add and compare, or LAT_MUL (7) cycles later for multiply.
- R7: done pulses for one cycle together with the last element's slot. For a length of 0 this is LAT cycles after acceptance, with no write-back. busy is high from the accepting edge until the edge after done.
- R8: While busy, start, vl_we and mk_we are ignored. No second instruction runs, and vl_o and mask_o keep their values.
- R9: After reset busy, done and wb_we are 0, vl_o is MAXVL and mask_o is all ones.
- R10: mk_we loads the whole mask from mk_wdata, visible on mask_o.
- R11: When use_mask is 0, every element below the length is written, whatever the mask holds.
- R12: ld_en writes ld_data into element ld_idx of vector ld_reg when idle. rd_data shows element rd_idx of vector rd_reg combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_en | input | 1 | Element load strobe |
| ld_reg | input | log2(NREG) | Vector to load |
| ld_idx | input | log2(MAXVL) | Element to load |
| ld_data | input | DW | Load value |
| rd_reg | input | log2(NREG) | Vector to read |
| rd_idx | input | log2(MAXVL) | Element to read |
| rd_data | output | DW | Read value |
| vl_we | input | 1 | Length write strobe |
| vl_wdata | input | DW | Requested length (scalar) |
| vl_o | output | log2(MAXVL)+1 | Current length |
| mk_we | input | 1 | Mask write strobe |
| mk_wdata | input | MAXVL | New mask |
| mask_o | output | MAXVL | Current mask |
| start | input | 1 | Instruction request |
| op_i | input | 3 | Operation code |
| use_mask | input | 1 | Gate writes by mask |
| dst | input | log2(NREG) | Destination vector |
| srca | input | log2(NREG) | First source vector |
| srcb | input | log2(NREG) | Second source vector |
| scalar | input | DW | Scalar operand |
| busy | output | 1 | Instruction in flight |
| done | output | 1 | Last element slot retiring |
| wb_we | output | 1 | Vector element write-back |
| wb_reg | output | log2(NREG) | Write-back vector |
| wb_idx | output | log2(MAXVL) | Write-back element |
| wb_data | output | DW | Write-back value |

## Verification
The hardest case to reach from the ports is a mask that was itself produced by a compare, combined with a request that arrives while the unit is busy. The stimulus first loads sources that match only at scattered indices. It then runs a compare with a short length, so the upper mask bits survive from an earlier direct load, and follows with a masked scalar add that depends on that mixed mask. In a separate long run, start, a length write and a mask write are driven in the middle of the instruction. The scoreboard would flag any extra write-back, and the frozen length and mask are then checked on vl_o and mask_o.

// File: rtl/vmask_pkg.sv
package vmask_pkg;
   typedef enum logic [2:0] {
      OP_ADDVV = 3'd0,
      OP_ADDSV = 3'd1,
      OP_MULVV = 3'd2,
      OP_MULSV = 3'd3,
      OP_CMPEQ = 3'd4
   } vop_e;

   function automatic logic op_is_mul(input vop_e o);
      return (o == OP_MULVV) || (o == OP_MULSV);
   endfunction

   function automatic logic op_uses_scalar(input vop_e o);
      return (o == OP_ADDSV) || (o == OP_MULSV);
   endfunction
endpackage

// File: rtl/vmask_rf.sv
module vmask_rf #(
   parameter int DW    = 16,
   parameter int NREG  = 4,
   parameter int DEPTH = 64
) (
   input  logic                     clk,
   input  logic                     we,
   input  logic [$clog2(NREG)-1:0]  wreg,
   input  logic [$clog2(DEPTH)-1:0] widx,
   input  logic [DW-1:0]            wdata,
   input  logic [$clog2(NREG)-1:0]  a_reg,
   input  logic [$clog2(DEPTH)-1:0] a_idx,
   output logic [DW-1:0]            a_data,
   input  logic [$clog2(NREG)-1:0]  b_reg,
   input  logic [$clog2(DEPTH)-1:0] b_idx,
   output logic [DW-1:0]            b_data,
   input  logic [$clog2(NREG)-1:0]  c_reg,
   input  logic [$clog2(DEPTH)-1:0] c_idx,
   output logic [DW-1:0]            c_data
);
   localparam int RW = $clog2(NREG);

   logic [DW-1:0] row_a [NREG];
   logic [DW-1:0] row_b [NREG];
   logic [DW-1:0] row_c [NREG];

   for (genvar r = 0; r < NREG; r++) begin : g_vec
      logic [DW-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
         if (we && (wreg == RW'(r))) mem[widx] <= wdata;
      end
      assign row_a[r] = mem[a_idx];
      assign row_b[r] = mem[b_idx];
      assign row_c[r] = mem[c_idx];
   end

   assign a_data = row_a[a_reg];
   assign b_data = row_b[b_reg];
   assign c_data = row_c[c_reg];
endmodule

// File: rtl/vmask_alu.sv
module vmask_alu
   import vmask_pkg::*;
#(
   parameter int DW = 16
) (
   input  vop_e          op,
   input  logic [DW-1:0] scal,
   input  logic [DW-1:0] va,
   input  logic [DW-1:0] vb,
   output logic [DW-1:0] res
);
   logic [DW-1:0] lhs;

   always_comb begin
      lhs = op_uses_scalar(op) ? scal : va;
      unique case (op)
         OP_MULVV, OP_MULSV: res = lhs * vb;
         OP_CMPEQ:           res = {{(DW-1){1'b0}}, (va == vb)};
         default:            res = lhs + vb;
      endcase
   end
endmodule

// File: rtl/vmask_pipe.sv
module vmask_pipe #(
   parameter int W     = 8,
   parameter int DEPTH = 7
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [$clog2(DEPTH+1)-1:0] inj,
   input  logic [W-1:0]               din,
   output logic [W-1:0]               dout
);
   logic [DEPTH:0][W-1:0] stg;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stg <= '0;
      end else begin
         stg[0] <= '0;
         for (int k = 1; k <= DEPTH; k++) begin
            stg[k] <= (int'(inj) == k) ? din : stg[k-1];
         end
      end
   end

   assign dout = stg[DEPTH];
endmodule

// File: rtl/vmask_seq.sv
module vmask_seq
   import vmask_pkg::*;
#(
   parameter int DW      = 16,
   parameter int NREG    = 4,
   parameter int MAXVL   = 64,
   parameter int LAT_ADD = 6,
   parameter int LAT_MUL = 7
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       ld_en,
   input  logic [$clog2(NREG)-1:0]    ld_reg,
   input  logic [$clog2(MAXVL)-1:0]   ld_idx,
   input  logic [DW-1:0]              ld_data,
   input  logic [$clog2(NREG)-1:0]    rd_reg,
   input  logic [$clog2(MAXVL)-1:0]   rd_idx,
   output logic [DW-1:0]              rd_data,
   input  logic                       vl_we,
   input  logic [DW-1:0]              vl_wdata,
   output logic [$clog2(MAXVL):0]     vl_o,
   input  logic                       mk_we,
   input  logic [MAXVL-1:0]           mk_wdata,
   output logic [MAXVL-1:0]           mask_o,
   input  logic                       start,
   input  logic [2:0]                 op_i,
   input  logic                       use_mask,
   input  logic [$clog2(NREG)-1:0]    dst,
   input  logic [$clog2(NREG)-1:0]    srca,
   input  logic [$clog2(NREG)-1:0]    srcb,
   input  logic [DW-1:0]              scalar,
   output logic                       busy,
   output logic                       done,
   output logic                       wb_we,
   output logic [$clog2(NREG)-1:0]    wb_reg,
   output logic [$clog2(MAXVL)-1:0]   wb_idx,
   output logic [DW-1:0]              wb_data
);
   localparam int RW      = $clog2(NREG);
   localparam int IW      = $clog2(MAXVL);
   localparam int LW      = IW + 1;
   localparam int SW      = $clog2(LAT_MUL + 1);
   localparam int ADD_INJ = LAT_MUL - LAT_ADD + 1;

   typedef struct packed {
      logic          last;
      logic          we;
      logic          cmp;
      logic [IW-1:0] idx;
      logic [DW-1:0] data;
   } slot_t;
   localparam int PW = $bits(slot_t);

   if (LAT_ADD < 1 || LAT_ADD > LAT_MUL) begin : g_bad_lat
      initial $fatal(1, "LAT_ADD must lie in 1..LAT_MUL");
   end
   if ((1 << IW) != MAXVL || MAXVL < 2) begin : g_bad_vl
      initial $fatal(1, "MAXVL must be a power of two");
   end
   if ((1 << RW) != NREG || NREG < 2) begin : g_bad_nreg
      initial $fatal(1, "NREG must be a power of two");
   end
   if (DW < LW) begin : g_bad_dw
      initial $fatal(1, "DW too narrow to carry a length");
   end

   logic                busy_q, issuing_q;
   logic [IW-1:0]       idx_q;
   logic [LW-1:0]       vl_q, vl_s, vl_m1, vl_cap;
   logic [MAXVL-1:0]    mask_q, mask_s;
   vop_e                op_s;
   logic                masked_s;
   logic [RW-1:0]       dst_s, sa_s, sb_s;
   logic [DW-1:0]       scal_s;
   logic                accept, cur_last, is_cmp, el_en, el_act;
   logic [DW-1:0]       va, vb, alu_res;
   logic [SW-1:0]       inj_sel;
   slot_t               slot_in, slot_out;
   logic                rf_we;
   logic [RW-1:0]       rf_reg;
   logic [IW-1:0]       rf_idx;
   logic [DW-1:0]       rf_data;

   assign accept   = start && !busy_q;
   assign vl_m1    = vl_s - LW'(1);
   assign el_act   = (vl_s != '0);
   assign cur_last = !el_act || ({1'b0, idx_q} == vl_m1);
   assign is_cmp   = (op_s == OP_CMPEQ);
   assign el_en    = is_cmp || !masked_s || mask_s[idx_q];
   assign vl_cap   = (vl_wdata > DW'(MAXVL)) ? LW'(MAXVL) : vl_wdata[LW-1:0];

   vmask_rf #(.DW(DW), .NREG(NREG), .DEPTH(MAXVL)) u_rf (
      .clk   (clk),
      .we    (rf_we),
      .wreg  (rf_reg),
      .widx  (rf_idx),
      .wdata (rf_data),
      .a_reg (sa_s),
      .a_idx (idx_q),
      .a_data(va),
      .b_reg (sb_s),
      .b_idx (idx_q),
      .b_data(vb),
      .c_reg (rd_reg),
      .c_idx (rd_idx),
      .c_data(rd_data)
   );

   vmask_alu #(.DW(DW)) u_alu (
      .op  (op_s),
      .scal(scal_s),
      .va  (va),
      .vb  (vb),
      .res (alu_res)
   );

   always_comb begin
      slot_in      = '0;
      slot_in.last = cur_last;
      slot_in.we   = el_act && el_en;
      slot_in.cmp  = is_cmp;
      slot_in.idx  = idx_q;
      slot_in.data = alu_res;
      if (!issuing_q)           inj_sel = '0;
      else if (op_is_mul(op_s)) inj_sel = SW'(1);
      else                      inj_sel = SW'(ADD_INJ);
   end

   vmask_pipe #(.W(PW), .DEPTH(LAT_MUL)) u_pipe (
      .clk  (clk),
      .rst_n(rst_n),
      .inj  (inj_sel),
      .din  (slot_in),
      .dout (slot_out)
   );

   always_comb begin
      wb_we   = slot_out.we && !slot_out.cmp;
      wb_reg  = dst_s;
      wb_idx  = slot_out.idx;
      wb_data = slot_out.data;
      done    = slot_out.last;
      if (busy_q) begin
         rf_we   = wb_we;
         rf_reg  = dst_s;
         rf_idx  = slot_out.idx;
         rf_data = slot_out.data;
      end else begin
         rf_we   = ld_en;
         rf_reg  = ld_reg;
         rf_idx  = ld_idx;
         rf_data = ld_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         issuing_q <= 1'b0;
         idx_q     <= '0;
         vl_q      <= LW'(MAXVL);
         mask_q    <= '1;
         vl_s      <= '0;
         mask_s    <= '0;
         op_s      <= OP_ADDVV;
         masked_s  <= 1'b0;
         dst_s     <= '0;
         sa_s      <= '0;
         sb_s      <= '0;
         scal_s    <= '0;
      end else begin
         if (!busy_q && vl_we) vl_q   <= vl_cap;
         if (!busy_q && mk_we) mask_q <= mk_wdata;
         if (accept) begin
            busy_q    <= 1'b1;
            issuing_q <= 1'b1;
            idx_q     <= '0;
            vl_s      <= vl_q;
            mask_s    <= mask_q;
            op_s      <= vop_e'(op_i);
            masked_s  <= use_mask;
            dst_s     <= dst;
            sa_s      <= srca;
            sb_s      <= srcb;
            scal_s    <= scalar;
         end
         if (issuing_q) begin
            if (cur_last) issuing_q <= 1'b0;
            else          idx_q     <= idx_q + IW'(1);
         end
         if (slot_out.we && slot_out.cmp) mask_q[slot_out.idx] <= slot_out.data[0];
         if (slot_out.last) busy_q <= 1'b0;
      end
   end

   assign busy   = busy_q;
   assign vl_o   = vl_q;
   assign mask_o = mask_q;
endmodule

// File: rtl/vmask_seq_chk.sv
module vmask_seq_chk #(
   parameter int MAXVL = 64,
   parameter int IW    = 6,
   parameter int LW    = 7
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             busy,
   input logic             done,
   input logic             wb_we,
   input logic [IW-1:0]    wb_idx,
   input logic [LW-1:0]    vl_o,
   input logic [LW-1:0]    vl_s,
   input logic [MAXVL-1:0] mask_s,
   input logic             masked_s
);
   a_r7_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> busy);

   a_r7_busy_drops: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy);

   a_r6_wb_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
      wb_we |-> busy);

   a_r5_wb_below_vl: assert property (@(posedge clk) disable iff (!rst_n)
      wb_we |-> ({1'b0, wb_idx} < vl_s));

   a_r5_vl_capped: assert property (@(posedge clk) disable iff (!rst_n)
      vl_o <= LW'(MAXVL));

   a_r4_mask_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_we && masked_s) |-> mask_s[wb_idx]);

   a_r8_frozen_snap: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(vl_s) && $stable(mask_s)));

   a_r8_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));
endmodule

bind vmask_seq vmask_seq_chk #(.MAXVL(MAXVL), .IW(IW), .LW(LW)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start   (start),
   .busy    (busy),
   .done    (done),
   .wb_we   (wb_we),
   .wb_idx  (wb_idx),
   .vl_o    (vl_o),
   .vl_s    (vl_s),
   .mask_s  (mask_s),
   .masked_s(masked_s)
);

// File: tb/tb_vmask_seq.sv
module tb_vmask_seq;
   localparam int DW = 16, NREG = 4, MAXVL = 64, LA = 6, LM = 7;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ld_en = 1'b0;
   logic [1:0]  ld_reg = '0, rd_reg = '0, dst = '0, srca = '0, srcb = '0;
   logic [5:0]  ld_idx = '0, rd_idx = '0;
   logic [15:0] ld_data = '0, vl_wdata = '0, scalar = '0;
   logic        vl_we = 1'b0, mk_we = 1'b0, start = 1'b0, use_mask = 1'b0;
   logic [63:0] mk_wdata = '0;
   logic [2:0]  op_i = '0;
   logic [15:0] rd_data, wb_data;
   logic [6:0]  vl_o;
   logic [63:0] mask_o;
   logic        busy, done, wb_we;
   logic [1:0]  wb_reg;
   logic [5:0]  wb_idx;

   always #5 clk = ~clk;

   vmask_seq #(.DW(DW), .NREG(NREG), .MAXVL(MAXVL), .LAT_ADD(LA), .LAT_MUL(LM)) dut (
      .clk(clk), .rst_n(rst_n),
      .ld_en(ld_en), .ld_reg(ld_reg), .ld_idx(ld_idx), .ld_data(ld_data),
      .rd_reg(rd_reg), .rd_idx(rd_idx), .rd_data(rd_data),
      .vl_we(vl_we), .vl_wdata(vl_wdata), .vl_o(vl_o),
      .mk_we(mk_we), .mk_wdata(mk_wdata), .mask_o(mask_o),
      .start(start), .op_i(op_i), .use_mask(use_mask), .dst(dst), .srca(srca),
      .srcb(srcb), .scalar(scalar),
      .busy(busy), .done(done), .wb_we(wb_we), .wb_reg(wb_reg), .wb_idx(wb_idx),
      .wb_data(wb_data)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int total = 0, bad = 0;

   typedef struct {
      int    rn;
      int    idx;
      int    data;
      int    at;
      string req;
   } exp_t;
   exp_t q[$];

   logic [15:0] sh [4][64];
   logic [63:0] smask;
   int          svl;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && wb_we) begin
         if (q.size() == 0) begin
            chk(1'b0, "R8", "write-back with nothing expected", int'(wb_idx), -1);
         end else begin
            exp_t e;
            e = q.pop_front();
            chk(int'(wb_reg) == e.rn && int'(wb_idx) == e.idx && int'(wb_data) == e.data,
                e.req, "write-back reg/idx/data",
                {int'(wb_reg), int'(wb_idx), int'(wb_data)}, {e.rn, e.idx, e.data});
            chk(cyc == e.at, "R6", "write-back cycle", cyc, e.at);
         end
      end
   end

   task automatic load_reg(input int r, input int base, input int step, input int eqmod);
      for (int i = 0; i < 64; i++) begin
         logic [15:0] v;
         v = 16'(base + i * step);
         if (eqmod > 0 && (i % eqmod) == 0) v = sh[0][i];
         @(negedge clk);
         ld_en = 1'b1; ld_reg = 2'(r); ld_idx = 6'(i); ld_data = v;
         sh[r][i] = v;
      end
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   task automatic check_reg(input int r, input string req);
      int badidx = -1;
      longint got = 0, ex = 0;
      for (int i = 0; i < 64; i++) begin
         rd_reg = 2'(r); rd_idx = 6'(i);
         #1;
         if (rd_data !== sh[r][i] && badidx < 0) begin
            badidx = i; got = rd_data; ex = sh[r][i];
         end
      end
      chk(badidx < 0, req, $sformatf("readback of vector %0d at element %0d", r, badidx), got, ex);
   endtask

   task automatic set_vl(input int v);
      @(negedge clk);
      vl_we = 1'b1; vl_wdata = 16'(v);
      @(negedge clk);
      vl_we = 1'b0;
      svl = (v > 64) ? 64 : v;
      chk(int'(vl_o) == svl, "R5", "length register", vl_o, svl);
   endtask

   task automatic set_mask(input logic [63:0] m);
      @(negedge clk);
      mk_we = 1'b1; mk_wdata = m;
      @(negedge clk);
      mk_we = 1'b0;
      smask = m;
      chk(mask_o == m, "R10", "mask register", mask_o, m);
   endtask

   task automatic run(input int op, input int d, input int a, input int b,
                      input logic [15:0] s, input bit msk, input bit poke, input string req);
      int          lat, acc, waited, n, last_at;
      logic [63:0] msnap;
      logic [15:0] res [64];
      bit          wr [64];
      lat   = (op == 2 || op == 3) ? LM : LA;
      msnap = smask;
      n     = svl;
      for (int i = 0; i < n; i++) begin
         logic [15:0] lhs;
         lhs = (op == 1 || op == 3) ? s : sh[a][i];
         case (op)
            2, 3:    res[i] = lhs * sh[b][i];
            4:       res[i] = {15'd0, sh[a][i] == sh[b][i]};
            default: res[i] = lhs + sh[b][i];
         endcase
         wr[i] = (op == 4) ? 1'b1 : (!msk || msnap[i]);
      end
      @(negedge clk);
      start = 1'b1; op_i = 3'(op); dst = 2'(d); srca = 2'(a); srcb = 2'(b);
      scalar = s; use_mask = msk;
      @(posedge clk);
      #1;
      acc = cyc;
      start = 1'b0;
      for (int i = 0; i < n; i++)
         if (op != 4 && wr[i]) q.push_back('{d, i, int'(res[i]), acc + i + lat, req});
      if (poke) begin
         @(negedge clk);
         @(negedge clk);
         start = 1'b1; op_i = 3'd2; dst = 2'd3; vl_we = 1'b1; vl_wdata = 16'd3;
         mk_we = 1'b1; mk_wdata = 64'h0;
         @(negedge clk);
         start = 1'b0; vl_we = 1'b0; mk_we = 1'b0;
      end
      waited = 0;
      forever begin
         @(negedge clk);
         if (done) break;
         waited++;
         if (waited > 500) break;
      end
      last_at = acc + ((n == 0) ? 0 : n - 1) + lat;
      chk(done && cyc == last_at, "R7", "done cycle", cyc, last_at);
      @(negedge clk);
      chk(!busy, "R7", "busy after done", busy, 0);
      chk(q.size() == 0, "R6", "write-backs still pending at done", q.size(), 0);
      for (int i = 0; i < n; i++) begin
         if (op == 4) smask[i] = res[i][0];
         else if (wr[i]) sh[d][i] = res[i];
      end
      if (poke) begin
         chk(int'(vl_o) == svl, "R8", "length kept after busy write", vl_o, svl);
         chk(mask_o == smask, "R8", "mask kept after busy write", mask_o, smask);
         repeat (LM + 2) @(negedge clk);
         chk(!busy, "R8", "no instruction taken while busy", busy, 0);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      chk(1'b0, "watchdog", "run did not finish", cyc, 200000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      smask = '1;
      svl   = 64;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(!busy && !done && !wb_we, "R9", "idle outputs in reset", {busy, done, wb_we}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !done && !wb_we, "R9", "idle outputs after reset", {busy, done, wb_we}, 0);
      chk(int'(vl_o) == 64, "R9", "length after reset", vl_o, 64);
      chk(mask_o == '1, "R9", "mask after reset", mask_o, 64'hFFFF_FFFF_FFFF_FFFF);

      load_reg(0, 1, 3, 0);
      load_reg(1, 200, -7, 5);
      load_reg(2, 16'h1000, 1, 0);
      load_reg(3, 16'hF000, 513, 0);
      for (int r = 0; r < 4; r++) check_reg(r, "R12");

      // R1, R5: short vector add, tail of destination untouched
      set_vl(8);
      run(0, 2, 0, 1, 16'd0, 1'b0, 1'b0, "R1");
      check_reg(2, "R5");
      // R1, R6: multiply latency
      run(2, 3, 0, 1, 16'd0, 1'b0, 1'b0, "R1");
      check_reg(3, "R1");
      // R2: scalar forms
      set_vl(20);
      run(1, 2, 0, 1, 16'h7FF3, 1'b0, 1'b0, "R2");
      run(3, 3, 2, 0, 16'h0101, 1'b0, 1'b0, "R2");
      check_reg(3, "R2");
      // R5 cap and R8 busy requests
      set_vl(100);
      run(0, 2, 2, 3, 16'd0, 1'b0, 1'b1, "R8");
      check_reg(2, "R5");
      // R4: masked multiply
      set_mask(64'hF0F0_0000_AAAA_5555);
      set_vl(40);
      run(2, 1, 0, 2, 16'd0, 1'b1, 1'b0, "R4");
      check_reg(1, "R4");
      // R11: mask present but not used
      run(0, 3, 0, 1, 16'd0, 1'b0, 1'b0, "R11");
      check_reg(3, "R11");
      // R3: compare with short length keeps upper mask bits
      set_vl(12);
      run(4, 0, 0, 1, 16'd0, 1'b1, 1'b0, "R3");
      chk(mask_o == smask, "R3", "mask after compare", mask_o, smask);
      check_reg(0, "R3");
      // R4: masked scalar add under compare-made mask
      set_vl(30);
      run(1, 2, 0, 1, 16'h0011, 1'b1, 1'b0, "R4");
      check_reg(2, "R4");
      // R7: zero length
      set_vl(0);
      run(0, 3, 0, 1, 16'd0, 1'b0, 1'b0, "R7");
      check_reg(3, "R7");
      // R6: single element multiply
      set_vl(1);
      run(3, 1, 0, 3, 16'h0203, 1'b0, 1'b0, "R6");
      check_reg(1, "R6");

      repeat (4) @(negedge clk);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule